// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the top-level operating state of a DRAM protocol controller. Software changes the state by issuing short command codes. The block reports its state, together with the cause of the last low-power entry, through one status word. There are four stable states: init, config, access and low-power. Each move between them passes through a transitional request state. In that state the block raises a request toward the memory side. It waits for an acknowledge, or for a fixed number of cycles, before it settles.

Low-power can be entered in two ways. Software can send a sleep command. The block can also enter on its own when hardware low-power is enabled and the memory side has been idle for a set number of consecutive cycles in access. The cause of entry decides how the exit works. After a software entry, the block waits for a wake-up command. After a hardware entry, wake-up commands are ignored and the block leaves low-power by itself when a new access request arrives. Every exit from low-power returns to access, never straight to config.

Top module: `dram_opstate`

## Requirements
- R1: After reset the status word is 0 (state init, no trigger cause) and `mem_req` is low.
- R2: `status[2:0]` holds the state: 0 init, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. `status[3]` is 0. `status[6:4]` holds the low-power cause: 0 none, 1 hardware, 2 software. Command codes on `cmd_code` are: 0 init, 1 config, 2 go, 3 sleep, 4 wake-up.
- R3: A config command in init or in access moves the state to config-request at the next edge. From config-request the block then settles in config.
- R4: A go command in config moves the state to access-request and then to access. An init command in config returns the state directly to init.
- R5: `mem_req` is high exactly while the state is transitional (2, 4, 6 or 7). A transitional state advances at the edge that ends a cycle in which `mem_ack` is high. With no acknowledge, it advances after `TIMEOUT` cycles (default 8).
- R6: A sleep command in access moves the state to low-power-entry-request and then to low-power, with cause 2.
- R7: With `hw_lp_en` high, `IDLE_CYCLES` consecutive cycles in access with `bus_idle` high (default 6) move the state to low-power-entry-request with cause 1. Any cycle without idle restarts the count. A sleep command in the same cycle as the final idle cycle takes precedence and gives cause 2. With `hw_lp_en` low, idle has no effect.
- R8: In low-power with cause 2, a wake-up command moves the state to low-power-exit-request and then to access. The cause is cleared to 0 on arrival in access. A config command in low-power is ignored.
- R9: In low-power with cause 1, a wake-up command is ignored. An `acc_req` pulse moves the state to low-power-exit-request and then to access.
- R10: Any command that is not listed as legal for the current state is ignored and leaves the status unchanged. This includes every command given during a transitional state and the codes 5 to 7.
- R11: In low-power with cause 2, `acc_req` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 3 | State-change command code |
| hw_lp_en | input | 1 | Allows automatic low-power entry on idle |
| bus_idle | input | 1 | Memory side reports no traffic this cycle |
| acc_req | input | 1 | New access request, wakes a hardware-entered low-power |
| mem_ack | input | 1 | Memory-side acknowledge of the pending transition |
| mem_req | output | 1 | Transition request toward the memory side |
| status | output | 7 | Cause in bits 6:4, state code in bits 2:0 |

## Verification
The assertions assume that the memory side acknowledges only a request that is pending. An acknowledge outside a transitional state has no meaning and is ignored. They also assume that `cmd_code` is looked at only in cycles where `cmd_valid` is high. The stimulus respects both assumptions. It raises `mem_ack` only in cycles where `mem_req` is expected to be high, and in some transitions it withholds the acknowledge so that the timeout path is exercised. It drives the idle and access-request inputs in the low-power states to show that the wrong wake source is ignored.

// File: rtl/dos_pkg.sv
package dos_pkg;

    typedef enum logic [2:0] {
        ST_INIT     = 3'd0,
        ST_CFG      = 3'd1,
        ST_CFG_REQ  = 3'd2,
        ST_ACC      = 3'd3,
        ST_ACC_REQ  = 3'd4,
        ST_LP       = 3'd5,
        ST_LP_ENTRY = 3'd6,
        ST_LP_EXIT  = 3'd7
    } op_state_e;

    typedef enum logic [2:0] {
        CMD_INIT  = 3'd0,
        CMD_CFG   = 3'd1,
        CMD_GO    = 3'd2,
        CMD_SLEEP = 3'd3,
        CMD_WAKE  = 3'd4
    } op_cmd_e;

    typedef enum logic [2:0] {
        CAUSE_NONE = 3'd0,
        CAUSE_HW   = 3'd1,
        CAUSE_SW   = 3'd2
    } lp_cause_e;

    typedef struct packed {
        op_state_e state;
        lp_cause_e cause;
    } op_regs_t;

    function automatic logic is_transitional(input op_state_e s);
        return (s == ST_CFG_REQ) || (s == ST_ACC_REQ) ||
               (s == ST_LP_ENTRY) || (s == ST_LP_EXIT);
    endfunction

endpackage

// File: rtl/dos_wait_timer.sv
module dos_wait_timer #(
    parameter int TIMEOUT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic ack,
    output logic settle
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] wait_d, wait_q;

    always_comb begin
        settle = active && (ack || (wait_q == LAST));
        wait_d = (active && !settle) ? wait_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wait_q <= '0;
        else        wait_q <= wait_d;
    end

    // R5: the wait counter never passes the timeout window
    a_r5_wait_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        32'(wait_q) < TIMEOUT);

    // R5: an idle timer (no pending request) holds at zero
    a_r5_wait_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> wait_q == '0);

endmodule

// File: rtl/dos_idle_detect.sv
module dos_idle_detect #(
    parameter int IDLE_CYCLES = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_access,
    input  logic enable,
    input  logic idle,
    output logic fire
);
    localparam int CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

    logic          counting;
    logic [CW-1:0] run_d, run_q;

    always_comb begin
        counting = in_access && enable && idle;
        fire     = counting && (run_q == LAST);
        run_d    = (counting && !fire) ? run_q + 1'b1 : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) run_q <= '0;
        else        run_q <= run_d;
    end

    // R7: a broken idle run clears the count
    a_r7_run_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |=> run_q == '0);

    generate
        if (IDLE_CYCLES > 1) begin : g_multi
            // R7: a trigger is always preceded by an enabled idle cycle in access
            a_r7_fire_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
                fire |-> $past(in_access && enable && idle));
        end
    endgenerate

endmodule

// File: rtl/dos_next_state.sv
module dos_next_state
    import dos_pkg::*;
(
    input  op_regs_t   cur,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       acc_req,
    input  logic       idle_fire,
    input  logic       settle,
    output op_regs_t   nxt
);
    logic cmd_cfg, cmd_go, cmd_init, cmd_sleep, cmd_wake;

    always_comb begin
        cmd_cfg   = cmd_valid && (cmd_code == CMD_CFG);
        cmd_go    = cmd_valid && (cmd_code == CMD_GO);
        cmd_init  = cmd_valid && (cmd_code == CMD_INIT);
        cmd_sleep = cmd_valid && (cmd_code == CMD_SLEEP);
        cmd_wake  = cmd_valid && (cmd_code == CMD_WAKE);

        nxt = cur;
        unique case (cur.state)
            ST_INIT: begin
                if (cmd_cfg) nxt.state = ST_CFG_REQ;
            end
            ST_CFG: begin
                if (cmd_go)        nxt.state = ST_ACC_REQ;
                else if (cmd_init) nxt.state = ST_INIT;
            end
            ST_ACC: begin
                if (cmd_cfg) begin
                    nxt.state = ST_CFG_REQ;
                end else if (cmd_sleep) begin
                    nxt.state = ST_LP_ENTRY;
                    nxt.cause = CAUSE_SW;
                end else if (idle_fire) begin
                    nxt.state = ST_LP_ENTRY;
                    nxt.cause = CAUSE_HW;
                end
            end
            ST_LP: begin
                if (cur.cause == CAUSE_HW) begin
                    if (acc_req) nxt.state = ST_LP_EXIT;
                end else if (cmd_wake) begin
                    nxt.state = ST_LP_EXIT;
                end
            end
            ST_CFG_REQ: begin
                if (settle) nxt.state = ST_CFG;
            end
            ST_ACC_REQ: begin
                if (settle) nxt.state = ST_ACC;
            end
            ST_LP_ENTRY: begin
                if (settle) nxt.state = ST_LP;
            end
            ST_LP_EXIT: begin
                if (settle) begin
                    nxt.state = ST_ACC;
                    nxt.cause = CAUSE_NONE;
                end
            end
            default: nxt = cur;
        endcase
    end

endmodule

// File: rtl/dram_opstate.sv
module dram_opstate
    import dos_pkg::*;
#(
    parameter int TIMEOUT     = 8,
    parameter int IDLE_CYCLES = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [2:0] cmd_code,
    input  logic       hw_lp_en,
    input  logic       bus_idle,
    input  logic       acc_req,
    input  logic       mem_ack,
    output logic       mem_req,
    output logic [6:0] status
);
    op_regs_t regs_d, regs_q;
    logic     settle, idle_fire, in_access;

    always_comb begin
        in_access = (regs_q.state == ST_ACC);
        mem_req   = is_transitional(regs_q.state);
        status    = {regs_q.cause, 1'b0, regs_q.state};
    end

    dos_wait_timer #(.TIMEOUT(TIMEOUT)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (mem_req),
        .ack    (mem_ack),
        .settle (settle)
    );

    dos_idle_detect #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_access (in_access),
        .enable    (hw_lp_en),
        .idle      (bus_idle),
        .fire      (idle_fire)
    );

    dos_next_state u_next (
        .cur       (regs_q),
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .acc_req   (acc_req),
        .idle_fire (idle_fire),
        .settle    (settle),
        .nxt       (regs_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{state: ST_INIT, cause: CAUSE_NONE};
        else        regs_q <= regs_d;
    end

    // R3: init only stays or heads for config-request
    a_r3_init_exit: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_INIT |=> regs_q.state inside {ST_INIT, ST_CFG_REQ});

    // R4: config leaves only toward access-request or init
    a_r4_cfg_exit: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_CFG |=> regs_q.state inside {ST_CFG, ST_ACC_REQ, ST_INIT});

    // R5: an acknowledged request is dropped at the next edge
    a_r5_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> !mem_req);

    // R6: low-power always carries a recorded cause
    a_r6_lp_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_LP |-> regs_q.cause != CAUSE_NONE);

    // R8: the exit request lands only in access
    a_r8_exit_to_access: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_LP_EXIT |=> regs_q.state inside {ST_LP_EXIT, ST_ACC});

    // R8: access never shows a stale cause
    a_r8_access_clean: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_ACC |-> regs_q.cause == CAUSE_NONE);

    // R9: hardware-entered low-power holds without an access request
    a_r9_hw_lp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_LP && regs_q.cause == CAUSE_HW && !acc_req
        |=> regs_q.state == ST_LP);

    // R10: a pending request is not abandoned for another state
    a_r10_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
        regs_q.state == ST_CFG_REQ |=> regs_q.state inside {ST_CFG_REQ, ST_CFG});

endmodule

// File: tb/dram_opstate_tb_top.sv
module dram_opstate_tb_top;

    localparam int TMO  = 8;
    localparam int IDLE = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_code = 3'd0;
    logic       hw_lp_en = 1'b0;
    logic       bus_idle = 1'b0;
    logic       acc_req = 1'b0;
    logic       mem_ack = 1'b0;
    logic       mem_req;
    logic [6:0] status;

    int    errors = 0;
    int    checks = 0;
    bit    done   = 1'b0;
    string tag    = "R1";

    // reference model state
    int m_state = 0, m_cause = 0, m_wait = 0, m_idle = 0;
    bit m_adv, m_fire;

    always #4 clk = ~clk;

    dram_opstate #(.TIMEOUT(TMO), .IDLE_CYCLES(IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .hw_lp_en(hw_lp_en), .bus_idle(bus_idle), .acc_req(acc_req),
        .mem_ack(mem_ack), .mem_req(mem_req), .status(status)
    );

    function automatic bit m_trans(input int s);
        return s == 2 || s == 4 || s == 6 || s == 7;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state = 0; m_cause = 0; m_wait = 0; m_idle = 0;
        end else begin
            m_adv = 1'b0;
            if (m_trans(m_state)) begin
                if (mem_ack || m_wait == TMO - 1) begin
                    m_adv = 1'b1; m_wait = 0;
                end else m_wait++;
            end
            m_fire = 1'b0;
            if (m_state == 3 && hw_lp_en && bus_idle) begin
                m_idle++;
                if (m_idle == IDLE) begin m_fire = 1'b1; m_idle = 0; end
            end else m_idle = 0;
            case (m_state)
                0: if (cmd_valid && cmd_code == 1) m_state = 2;
                1: if (cmd_valid && cmd_code == 2) m_state = 4;
                   else if (cmd_valid && cmd_code == 0) m_state = 0;
                3: if (cmd_valid && cmd_code == 1) m_state = 2;
                   else if (cmd_valid && cmd_code == 3) begin m_state = 6; m_cause = 2; end
                   else if (m_fire) begin m_state = 6; m_cause = 1; end
                5: if (m_cause == 1) begin if (acc_req) m_state = 7; end
                   else if (cmd_valid && cmd_code == 4) m_state = 7;
                2: if (m_adv) m_state = 1;
                4: if (m_adv) m_state = 3;
                6: if (m_adv) m_state = 5;
                7: if (m_adv) begin m_state = 3; m_cause = 0; end
                default: ;
            endcase
        end
    end

    task automatic chk(input string t, input logic [6:0] got, input logic [6:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: status got 0x%02h expected 0x%02h", t, got, exp);
        end
    endtask

    task automatic cmp_model();
        logic [6:0] e;
        e = 7'((m_cause << 4) | m_state);
        chk(tag, status, e);
        checks++;
        if (mem_req !== m_trans(m_state)) begin
            errors++;
            $display("FAIL R5 (%s): mem_req got %0b expected %0b", tag, mem_req, m_trans(m_state));
        end
    endtask

    task automatic cyc(input bit v, input bit [2:0] c, input bit ack,
                       input bit idl, input bit ar);
        cmd_valid = v; cmd_code = c; mem_ack = ack; bus_idle = idl; acc_req = ar;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmp_model();
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, got timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        tag = "R1";
        chk("R1 reset status", status, 7'h00);
        checks++;
        if (mem_req !== 1'b0) begin
            errors++;
            $display("FAIL R1: mem_req got %0b expected 0", mem_req);
        end
        rst_n = 1'b1;
        @(negedge clk);

        tag = "R10";
        cyc(1, 3'd2, 0, 0, 0); chk("R10 go in init", status, 7'h00);
        cyc(1, 3'd3, 0, 0, 0);
        cyc(1, 3'd4, 0, 0, 0);
        cyc(1, 3'd7, 0, 0, 0); chk("R10 code 7 in init", status, 7'h00);

        tag = "R3";
        cyc(1, 3'd1, 0, 0, 0); chk("R3 cfg from init", status, 7'h02);
        tag = "R5";
        repeat (7) cyc(0, 3'd0, 0, 0, 0);
        chk("R5 still waiting", status, 7'h02);
        cyc(0, 3'd0, 0, 0, 0); chk("R5 timeout settles config", status, 7'h01);

        tag = "R10";
        cyc(1, 3'd3, 0, 0, 0); cyc(1, 3'd5, 0, 0, 0);
        chk("R10 sleep/code5 in config", status, 7'h01);

        tag = "R4";
        cyc(1, 3'd2, 0, 0, 0); chk("R4 go from config", status, 7'h04);
        tag = "R10";
        cyc(1, 3'd1, 0, 0, 0); chk("R10 cfg during request", status, 7'h04);
        tag = "R5";
        cyc(0, 3'd0, 1, 0, 0); chk("R5 ack settles access", status, 7'h03);

        tag = "R3";
        cyc(1, 3'd1, 0, 0, 0); chk("R3 cfg from access", status, 7'h02);
        cyc(0, 3'd0, 1, 0, 0); chk("R3 settle config", status, 7'h01);
        tag = "R4";
        cyc(1, 3'd0, 0, 0, 0); chk("R4 init from config", status, 7'h00);
        cyc(1, 3'd1, 0, 0, 0); cyc(0, 3'd0, 1, 0, 0);
        cyc(1, 3'd2, 0, 0, 0); cyc(0, 3'd0, 1, 0, 0);
        chk("R4 back in access", status, 7'h03);

        tag = "R10";
        cyc(1, 3'd2, 0, 0, 0); cyc(1, 3'd6, 0, 0, 0); cyc(1, 3'd4, 0, 0, 0);
        chk("R10 go/code6/wake in access", status, 7'h03);

        tag = "R6";
        cyc(1, 3'd3, 0, 0, 0); chk("R6 sleep entry", status, 7'h26);
        cyc(0, 3'd0, 1, 0, 0); chk("R6 low-power sw", status, 7'h25);
        tag = "R8";
        cyc(1, 3'd1, 0, 0, 0); chk("R8 cfg in low-power", status, 7'h25);
        tag = "R11";
        cyc(0, 3'd0, 0, 0, 1); chk("R11 acc_req in sw low-power", status, 7'h25);
        tag = "R8";
        cyc(1, 3'd4, 0, 0, 0); chk("R8 wake exit request", status, 7'h27);
        cyc(0, 3'd0, 1, 0, 0); chk("R8 access, cause cleared", status, 7'h03);

        tag = "R7";
        hw_lp_en = 1'b1;
        repeat (5) cyc(0, 3'd0, 0, 1, 0);
        chk("R7 five idle cycles", status, 7'h03);
        cyc(0, 3'd0, 0, 1, 0); chk("R7 hw entry", status, 7'h16);
        cyc(0, 3'd0, 1, 1, 0); chk("R7 low-power hw", status, 7'h15);
        tag = "R9";
        cyc(1, 3'd4, 0, 0, 0); chk("R9 wake ignored", status, 7'h15);
        cyc(0, 3'd0, 0, 0, 1); chk("R9 acc_req exit", status, 7'h17);
        cyc(0, 3'd0, 1, 0, 0); chk("R9 back in access", status, 7'h03);

        tag = "R7";
        repeat (5) cyc(0, 3'd0, 0, 1, 0);
        cyc(0, 3'd0, 0, 0, 0);
        repeat (5) cyc(0, 3'd0, 0, 1, 0);
        chk("R7 broken run no entry", status, 7'h03);
        cyc(1, 3'd3, 0, 1, 0); chk("R7 sleep wins over idle", status, 7'h26);
        cyc(0, 3'd0, 1, 0, 0);
        cyc(1, 3'd4, 0, 0, 0);
        tag = "R5";
        repeat (7) cyc(0, 3'd0, 0, 0, 0);
        chk("R5 exit waiting", status, 7'h27);
        cyc(0, 3'd0, 0, 0, 0); chk("R5 exit timeout", status, 7'h03);

        tag = "R7";
        hw_lp_en = 1'b0;
        repeat (20) cyc(0, 3'd0, 0, 1, 0);
        chk("R7 disabled stays access", status, 7'h03);

        tag = "R2";
        cyc(1, 3'd1, 0, 0, 0); chk("R2 config-request code", status, 7'h02);
        cyc(0, 3'd0, 1, 0, 0); chk("R2 config code", status, 7'h01);

        finish_run();
    end

endmodule